// File: doc/BRIEF.md
# Register-Programmed Watchdog Timer

This block is a watchdog timer that software controls through three 32-bit registers on a simple synchronous bus. The bus has an address, a write strobe, write data and combinational read data. Software picks two power-of-two timeout periods, each with a 4-bit code: one for the first period after the timer is switched on, and one for every later period. It then turns the timer on and keeps it alive by writing a fixed key word to a dedicated restart register. If the down-counter runs out, the block either pulses a reset output straight away, or first raises an interrupt and pulses reset only if a second period passes with no restart.

The control sits in a four-state machine:
- `ST_IDLE`: the timer is switched off.
- `ST_RUN`: the timer is counting.
- `ST_WARN`: the interrupt is pending and the timer is counting a second period.
- `ST_BITE`: the reset pulse is being driven.

The transitions are:
- `IDLE->RUN`: a control write sets the enable bit. The counter takes the initial period.
- `RUN->RUN`: a valid key write reloads the counter with the normal period.
- `RUN->WARN`: the counter expires in interrupt mode. The counter takes the normal period.
- `RUN->BITE`: the counter expires in reset mode.
- `WARN->RUN`: a valid key write clears the interrupt and reloads the normal period.
- `WARN->BITE`: a second expiry with no restart.
- `BITE->RUN`: the pulse ends and the counter takes the normal period.
- `any->IDLE`: a control write clears the enable bit.

Top module: `wdog_timer`

## Requirements
- R1: After reset, `wd_irq` and `wd_rst` are low, and all three registers read as zero.
- R2: Control is at byte offset 0x00 and holds the enable bit in bit 0 and the mode bit in bit 1 (1 = interrupt first, 0 = direct reset). The timeout register is at offset 0x04 and holds the normal code in bits [3:0] and the initial code in bits [7:4]. Both registers read back their last written value, with unused bits reading as 0. The restart register at 0x0C, and any unmapped offset, read as 0.
- R3: A code c selects a period of P = 2^(BASE_EXP+c) clock cycles. A control write that sets the enable bit while the timer is off loads the initial period, and the counter expires at the P-th rising edge after the write edge.
- R4: While the timer is enabled and not in its reset pulse, a write of exactly 32'h0000_0076 to offset 0x0C restarts the period using the normal code, counted from the write edge.
- R5: A write to 0x0C with any other value does not change the countdown. A key write has no effect while the timer is off or while the reset pulse is running.
- R6: In direct-reset mode, expiry drives `wd_rst` high for exactly RST_CYCLES cycles, starting right after the expiry edge.
- R7: In interrupt mode, the first expiry raises `wd_irq` and starts a normal period. If that period expires with no restart, `wd_irq` drops and `wd_rst` is pulsed.
- R8: A valid key write while the interrupt is pending clears `wd_irq` on the next edge and restarts a normal period.
- R9: When the reset pulse ends, the timer keeps running and the next expiry comes one normal period after the release edge.
- R10: A control write with bit 0 clear stops the timer in any state. Both outputs are low after that edge, and no expiry follows.
- R11: A new timeout code, or a control write that keeps bit 0 set, does not disturb the period in progress. A new code is used from the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| wd_irq | output | 1 | Pre-reset interrupt, high while pending |
| wd_rst | output | 1 | Reset pulse, RST_CYCLES cycles long |

## Verification
An internal fault shows at the ports only as a timing error: an interrupt or reset edge that comes a cycle early or late, or does not come at all. A counter that reloads wrongly or misses a reload stays hidden until the next expiry, which can be a whole period away. For that reason every scenario follows each restart, ignored write and code change through to the expiry edge it predicts. It samples both outputs one cycle before that edge and at that edge. A wrong state decode, such as a pulse left running or an interrupt that fails to clear, is visible one cycle after the write that should have changed it.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_WARN,
        ST_BITE
    } wd_state_e;

    localparam int unsigned OFF_CTRL  = 32'h00;
    localparam int unsigned OFF_TMO   = 32'h04;
    localparam int unsigned OFF_KICK  = 32'h0C;
    localparam logic [31:0] KICK_KEY  = 32'h0000_0076;
    localparam int          CODE_W    = 4;

endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              ctrl_wr,
    output logic              en_new,
    output logic              kick,
    output logic              mode,
    output logic [CODE_W-1:0] code_init,
    output logic [CODE_W-1:0] code_norm
);

    logic [1:0]          ctrl_q;
    logic [2*CODE_W-1:0] tmo_q;
    logic                sel_ctrl, sel_tmo, sel_kick;

    assign sel_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
    assign sel_tmo  = (bus_addr == ADDR_W'(OFF_TMO));
    assign sel_kick = (bus_addr == ADDR_W'(OFF_KICK));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            tmo_q  <= '0;
        end else if (bus_we) begin
            if (sel_ctrl) ctrl_q <= bus_wdata[1:0];
            if (sel_tmo)  tmo_q  <= bus_wdata[2*CODE_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl)     bus_rdata = {30'd0, ctrl_q};
        else if (sel_tmo) bus_rdata = {{(32-2*CODE_W){1'b0}}, tmo_q};
    end

    assign ctrl_wr   = bus_we && sel_ctrl;
    assign en_new    = bus_wdata[0];
    assign kick      = bus_we && sel_kick && (bus_wdata == KICK_KEY);
    assign mode      = ctrl_q[1];
    assign code_norm = tmo_q[CODE_W-1:0];
    assign code_init = tmo_q[2*CODE_W-1:CODE_W];

    // R2: a stored control value survives cycles with no control write
    p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> (ctrl_q == $past(ctrl_q)));

endmodule

// File: rtl/wdog_period.sv
module wdog_period
    import wdog_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int BASE_EXP = 16
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  load
);

    localparam int MAX_EXP = BASE_EXP + (1 << CODE_W) - 1;

    initial begin
        if (MAX_EXP >= CNT_W) $error("counter too narrow for longest period");
    end

    // Count runs from P-1 down to 0, so expiry falls P edges after the load
    assign load = (CNT_W'(1) << (BASE_EXP + int'(code))) - CNT_W'(1);

endmodule

// File: rtl/wdog_engine.sv
module wdog_engine
    import wdog_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int RST_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             en_new,
    input  logic             kick,
    input  logic             mode,
    input  logic [CNT_W-1:0] load_init,
    input  logic [CNT_W-1:0] load_norm,
    output logic             wd_irq,
    output logic             wd_rst,
    output wd_state_e        state_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam int BW = $clog2(RST_CYCLES + 1);
    localparam logic [BW-1:0] BITE_LAST = BW'(RST_CYCLES - 1);

    wd_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [BW-1:0]    bite_q, bite_d;
    logic             stop;

    assign stop = ctrl_wr && !en_new;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            bite_q <= '0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            bite_q <= bite_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        bite_d = bite_q;
        unique case (st_q)
            ST_IDLE: begin
                if (ctrl_wr && en_new) begin
                    st_d  = ST_RUN;
                    cnt_d = load_init;
                end
            end
            ST_RUN, ST_WARN: begin
                if (stop) begin
                    st_d = ST_IDLE;
                end else if (kick) begin
                    st_d  = ST_RUN;
                    cnt_d = load_norm;
                end else if (cnt_q == '0) begin
                    if (st_q == ST_RUN && mode) begin
                        st_d  = ST_WARN;
                        cnt_d = load_norm;
                    end else begin
                        st_d   = ST_BITE;
                        bite_d = '0;
                    end
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_BITE: begin
                if (stop) begin
                    st_d = ST_IDLE;
                end else if (bite_q == BITE_LAST) begin
                    st_d  = ST_RUN;
                    cnt_d = load_norm;
                end else begin
                    bite_d = bite_q + 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        wd_irq = 1'b0;
        wd_rst = 1'b0;
        unique case (st_q)
            ST_WARN: wd_irq = 1'b1;
            ST_BITE: wd_rst = 1'b1;
            default: ;
        endcase
    end

    assign state_o = st_q;
    assign cnt_o   = cnt_q;

    // R3: an undisturbed running count steps down by one per cycle
    p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && !ctrl_wr && !kick && cnt_q != '0)
        |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R4: a valid key restarts with the normal period
    p_kick_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_RUN || st_q == ST_WARN) && kick && !stop)
        |=> (st_q == ST_RUN && cnt_q == $past(load_norm) && !wd_irq));

    // R6: the reset pulse is held until its last cycle
    p_bite_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BITE && bite_q != BITE_LAST && !ctrl_wr) |=> wd_rst);

    // R7: second expiry with no restart moves from interrupt to reset
    p_warn_bite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WARN && cnt_q == '0 && !kick && !ctrl_wr)
        |=> (wd_rst && !wd_irq));

    // R9: pulse release resumes counting with the normal period
    p_bite_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BITE && bite_q == BITE_LAST && !ctrl_wr)
        |=> (!wd_rst && st_q == ST_RUN && cnt_q == $past(load_norm)));

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int CNT_W      = 32,
    parameter int BASE_EXP   = 16,
    parameter int RST_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wd_irq,
    output logic              wd_rst
);

    localparam int NPER = 2;

    logic              ctrl_wr, en_new, kick, mode;
    logic [CODE_W-1:0] code_init, code_norm;
    logic [CODE_W-1:0] codes [NPER];
    logic [CNT_W-1:0]  loads [NPER];
    wd_state_e         st;
    logic [CNT_W-1:0]  cnt;

    wdog_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ctrl_wr   (ctrl_wr),
        .en_new    (en_new),
        .kick      (kick),
        .mode      (mode),
        .code_init (code_init),
        .code_norm (code_norm)
    );

    assign codes[0] = code_init;
    assign codes[1] = code_norm;

    for (genvar g = 0; g < NPER; g++) begin : g_per
        wdog_period #(.CNT_W(CNT_W), .BASE_EXP(BASE_EXP)) u_per (
            .code (codes[g]),
            .load (loads[g])
        );
    end

    wdog_engine #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .en_new    (en_new),
        .kick      (kick),
        .mode      (mode),
        .load_init (loads[0]),
        .load_norm (loads[1]),
        .wd_irq    (wd_irq),
        .wd_rst    (wd_rst),
        .state_o   (st),
        .cnt_o     (cnt)
    );

    // R5: a wrong key at the restart offset leaves the countdown running
    p_bad_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFF_KICK) && bus_wdata != KICK_KEY
         && st == ST_RUN && cnt != '0)
        |=> (cnt == $past(cnt) - 1'b1));

    // R10: a control write clearing bit 0 silences both outputs
    p_stop_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFF_CTRL) && !bus_wdata[0])
        |=> (!wd_rst && !wd_irq && st == ST_IDLE));

endmodule

// File: tb/wdog_timer_bench.sv
`timescale 1ns/1ps
module wdog_timer_bench;

    localparam int BASE = 2;
    localparam int RCY  = 8;
    localparam logic [7:0] A_CTRL = 8'h00, A_TMO = 8'h04, A_KICK = 8'h0C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wd_irq, wd_rst;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    wdog_timer #(.ADDR_W(8), .CNT_W(32), .BASE_EXP(BASE), .RST_CYCLES(RCY)) u_wdog_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wd_irq(wd_irq), .wd_rst(wd_rst)
    );

    function automatic int per(input int c);
        return 1 << (BASE + c);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic outs(input string tag, input bit irq, input bit rst);
        check(tag, {30'd0, wd_irq, wd_rst}, {30'd0, irq, rst});
    endtask

    // Called at a negedge; the write lands on the next rising edge; returns at the following negedge
    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic advance(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic random_run();
        int ci, cn, m, P, el, ops, d, kind;
        logic [31:0] v;
        ci = $urandom_range(0, 4);
        cn = $urandom_range(0, 4);
        m  = $urandom_range(0, 1);
        bus_wr(A_TMO, 32'(ci * 16 + cn));
        bus_wr(A_CTRL, 32'(m * 2 + 1));
        P = per(ci); el = 0;
        ops = $urandom_range(0, 4);
        for (int k = 0; k < ops; k++) begin
            if (P - el - 1 >= 1) begin
                d = $urandom_range(1, P - el - 1);
                advance(d - 1);
                outs("R3 no expiry before period end", 0, 0);
                kind = $urandom_range(0, 3);
                if (kind == 0) begin
                    v = $urandom;
                    if (v == 32'h76) v = 32'h176;
                    bus_wr(A_KICK, v);          // R5 wrong key ignored
                    el += d;
                end else if (kind == 1) begin
                    bus_wr(A_KICK, 32'h76);     // R4 valid restart
                    el = 0; P = per(cn);
                end else if (kind == 2) begin
                    cn = $urandom_range(0, 4);
                    bus_wr(A_TMO, 32'(ci * 16 + cn)); // R11 new code waits for reload
                    el += d;
                end else begin
                    bus_wr(A_CTRL, 32'(m * 2 + 1));   // R11 re-enable does not reload
                    el += d;
                end
            end
        end
        advance(P - el - 1);
        outs("R3/R4/R5/R11 quiet one cycle before expiry", 0, 0);
        advance(1);
        if (m == 1) begin
            outs("R7 first expiry raises interrupt", 1, 0);
            advance(per(cn) - 1);
            outs("R7 interrupt held for normal period", 1, 0);
            advance(1);
        end
        outs("R6/R7 reset pulse starts", 0, 1);
        advance(RCY - 1);
        outs("R6 reset held for full length", 0, 1);
        advance(1);
        outs("R6 reset released after RST_CYCLES", 0, 0);
        advance(per(cn) - 1);
        outs("R9 quiet before next expiry", 0, 0);
        advance(1);
        if (m == 1) outs("R9 next expiry after normal period", 1, 0);
        else        outs("R9 next expiry after normal period", 0, 1);
        bus_wr(A_CTRL, 32'd0);
        outs("R10 stop clears outputs", 0, 0);
    endtask

    initial begin
        logic [31:0] d;
        void'($urandom(32'd1234));
        advance(3);
        outs("R1 outputs after reset", 0, 0);
        rst_n = 1'b1;
        advance(1);
        outs("R1 outputs after reset release", 0, 0);
        bus_rd(A_CTRL, d); check("R1 control reset", d, 0);
        bus_rd(A_TMO, d);  check("R1 timeout reset", d, 0);
        bus_rd(A_KICK, d); check("R1 restart reads zero", d, 0);

        // R2 register map and readback
        bus_wr(A_TMO, 32'hFFFF_FF3C);
        bus_rd(A_TMO, d);  check("R2 timeout readback", d, 32'h3C);
        bus_wr(A_CTRL, 32'hFFFF_FFFE);
        bus_rd(A_CTRL, d); check("R2 control readback", d, 32'h2);
        bus_wr(A_KICK, 32'h76);
        bus_rd(A_KICK, d); check("R2 restart reads zero", d, 0);
        bus_rd(8'h08, d);  check("R2 unmapped reads zero", d, 0);

        // R5 key while off has no effect
        bus_wr(A_KICK, 32'h76);
        advance(300);
        outs("R5 key while disabled", 0, 0);

        // R10 stop mid-run
        bus_wr(A_TMO, 32'h00);
        bus_wr(A_CTRL, 32'h1);
        advance(1);
        bus_wr(A_CTRL, 32'h0);
        outs("R10 stopped", 0, 0);
        advance(50);
        outs("R10 no expiry after stop", 0, 0);

        // R3 longer code boundary: init 6 -> 256 cycles
        bus_wr(A_TMO, 32'h60);
        bus_wr(A_CTRL, 32'h1);
        advance(per(6) - 1);
        outs("R3 code 6 quiet before end", 0, 0);
        advance(1);
        outs("R3 code 6 expires on time", 0, 1);
        bus_wr(A_CTRL, 32'h0);

        // R8 restart clears pending interrupt
        bus_wr(A_TMO, 32'h01);
        bus_wr(A_CTRL, 32'h3);
        advance(per(0));
        outs("R8 interrupt pending", 1, 0);
        advance(1);
        bus_wr(A_KICK, 32'h76);
        outs("R8 interrupt cleared by key", 0, 0);
        advance(per(1) - 1);
        outs("R8 quiet for normal period", 0, 0);
        advance(1);
        outs("R8 interrupt again after normal period", 1, 0);
        bus_wr(A_CTRL, 32'h0);

        // R5 key during reset pulse ignored
        bus_wr(A_TMO, 32'h00);
        bus_wr(A_CTRL, 32'h1);
        advance(per(0));
        outs("R6 pulse begins", 0, 1);
        advance(1);
        bus_wr(A_KICK, 32'h76);
        advance(RCY - 3);
        outs("R5 key during pulse does not cut it", 0, 1);
        advance(1);
        outs("R6 pulse ends on time", 0, 0);
        bus_wr(A_CTRL, 32'h0);

        // R11 re-enable write while running keeps period
        bus_wr(A_TMO, 32'h20);
        bus_wr(A_CTRL, 32'h1);
        advance(9);
        bus_wr(A_CTRL, 32'h1);
        advance(5);
        outs("R11 re-enable did not reload", 0, 0);
        advance(1);
        outs("R11 expiry at original time", 0, 1);
        bus_wr(A_CTRL, 32'h0);

        for (int it = 0; it < 40; it++) random_run();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 190000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule